// File: doc/BRIEF.md
# Miscellaneous Immediate Instruction Decoder

This block classifies one 32-bit instruction word taken from the miscellaneous-immediate group of a 32-bit RISC instruction set. The word arrives with a valid strobe. The decoder sorts it into exactly one of six classes:

- wide move of a 16-bit value into a register;
- move of a 16-bit value into the top half of a register;
- hint;
- immediate write to the current status register;
- immediate write to the saved status register;
- undefined.

For the class it picks, it also supplies the operands the execute stage needs: destination register, immediate, field byte mask and hint kind.

Two immediate forms are built. The status-register writes use an 8-bit constant rotated right by an even amount. The move forms use a 16-bit constant assembled from two separate fields. One opcode value is shared by the hints and the current-status write, and the Rn field tells them apart. A parameter puts a register stage on the outputs, so the decoded result and its strobe appear one clock after the input.

Top module: `misc_imm_decoder`

## Requirements

Field positions used below: opcode = insn[24:21], Rn = insn[19:16], Rd = insn[15:12], rotate = insn[11:8], imm8 = insn[7:0]. Class codes on out_class: 0 = wide move, 1 = move top, 2 = hint, 3 = current status write, 4 = saved status write, 7 = undefined. Fields a class does not use are driven to zero.

- R1: With the registered stage enabled (default), out_valid equals in_valid delayed by one clock. The decoded outputs are captured only when in_valid is high, and they hold their value while in_valid is low.
- R2: While rst is high at a clock edge, out_valid and every decoded output go to zero.
- R3: Opcode 0x8 gives class 0. out_rd is Rd. out_imm is the 16-bit value {insn[19:16], insn[11:0]}, zero-extended to 32 bits. out_mask and out_hint are zero.
- R4: Opcode 0xA gives class 1. out_rd is Rd. out_imm is the same 16-bit value placed in bits [31:16] with zeros in bits [15:0], because the lower half of Rd is kept.
- R5: Opcode 0x9 with Rn = 0 and imm8 ≤ 4 gives class 2. out_hint = imm8, where 0 = no-op, 1 = yield, 2 = wait for event, 3 = wait for interrupt and 4 = send event. out_rd, out_imm and out_mask are zero.
- R6: Opcode 0x9 with Rn = 0 and imm8 > 4 gives class 7.
- R7: Opcode 0x9 with Rn ≠ 0 gives class 3. out_imm is the rotated immediate and out_mask = insn[19:16].
- R8: Opcode 0xB gives class 4 for any Rn. out_imm is the rotated immediate and out_mask = insn[19:16].
- R9: The rotated immediate is imm8, zero-extended to 32 bits, rotated right by 2 × rotate. A rotate of 0 passes imm8 through unchanged.
- R10: Any opcode outside 0x8..0xB gives class 7, with out_rd, out_imm, out_mask and out_hint all zero.
- R11: out_undef is high exactly when out_class is 7.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result is present |
| out_class | output | 3 | Class code |
| out_undef | output | 1 | Undefined encoding |
| out_rd | output | 4 | Destination register index |
| out_imm | output | 32 | Assembled or rotated immediate |
| out_mask | output | 4 | Status-write field byte mask |
| out_hint | output | 3 | Hint kind |

## Verification

Rotation is exercised at amounts 0, 1 and 15, and with an imm8 whose bits wrap past bit 0.

- A rotator that shifts instead of rotating would lose the wrapped bits.
- A rotator that uses the raw 4-bit amount instead of twice it would put the constant in the wrong place.

The hint boundary is tested at imm8 values 4, 5 and 255, and also at Rn = 1 with imm8 = 0.

- A decoder that checks the wrong field would turn a status write into a no-op, or a hint into a status write.

Saved-status writes are driven with Rn = 0 to make sure Rn does not reach that class. Move-top must keep the constant out of the low half. Opcodes next to the group (0x7 and 0xC) must come out undefined with zeroed fields. Idle cycles between valid words must leave the outputs exactly as they were.

// File: rtl/misc_imm_pkg.sv
package misc_imm_pkg;
  localparam int INSN_W = 32;
  localparam int DATA_W = 32;
  localparam int REG_W  = 4;
  localparam int OPC_W  = 4;
  localparam int MASK_W = 4;
  localparam int HINT_W = 3;
  localparam int IMM8_W = 8;
  localparam int ROT_W  = 4;
  localparam int HALF_W = DATA_W / 2;
  localparam int LO12_W = 12;

  localparam int OPC_LSB = 21;
  localparam int RN_LSB  = 16;
  localparam int RD_LSB  = 12;
  localparam int ROT_LSB = 8;

  localparam logic [OPC_W-1:0] OPC_MOVW    = 4'h8;
  localparam logic [OPC_W-1:0] OPC_HINTPSR = 4'h9;
  localparam logic [OPC_W-1:0] OPC_MOVT    = 4'hA;
  localparam logic [OPC_W-1:0] OPC_PSRSAV  = 4'hB;
  localparam int HINT_MAX = 4;

  typedef enum logic [2:0] {
    CLS_MOVW    = 3'd0,
    CLS_MOVT    = 3'd1,
    CLS_HINT    = 3'd2,
    CLS_PSR_CUR = 3'd3,
    CLS_PSR_SAV = 3'd4,
    CLS_UNDEF   = 3'd7
  } cls_e;

  typedef struct packed {
    cls_e              cls;
    logic              undef;
    logic [REG_W-1:0]  rd;
    logic [DATA_W-1:0] imm;
    logic [MASK_W-1:0] mask;
    logic [HINT_W-1:0] hint;
  } dec_t;
endpackage

// File: rtl/misc_imm_fields.sv
module misc_imm_fields
  import misc_imm_pkg::*;
(
  input  logic [ROT_W-1:0]  rot_amt,
  input  logic [IMM8_W-1:0] imm8,
  input  logic [REG_W-1:0]  hi4,
  input  logic [LO12_W-1:0] lo12,
  output logic [DATA_W-1:0] rot_imm,
  output logic [HALF_W-1:0] wide_imm
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] zext;
  logic [SH_W-1:0]   amt;

  assign zext     = {{(DATA_W-IMM8_W){1'b0}}, imm8};
  assign amt      = SH_W'({rot_amt, 1'b0});
  assign wide_imm = {hi4, lo12};

  // rotate right: output bit i takes source bit (i + amt) mod DATA_W
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      rot_imm[i] = zext[SH_W'(i) + amt];
    end
  end
endmodule

// File: rtl/misc_imm_classify.sv
module misc_imm_classify
  import misc_imm_pkg::*;
(
  input  logic [OPC_W-1:0]  opc,
  input  logic [REG_W-1:0]  rn,
  input  logic [REG_W-1:0]  rd,
  input  logic [IMM8_W-1:0] imm8,
  input  logic [DATA_W-1:0] rot_imm,
  input  logic [HALF_W-1:0] wide_imm,
  output dec_t              dec
);
  logic hint_ok;
  assign hint_ok = (imm8 <= IMM8_W'(HINT_MAX));

  always_comb begin
    dec       = '0;
    dec.cls   = CLS_UNDEF;
    dec.undef = 1'b1;
    unique case (opc)
      OPC_MOVW: begin
        dec.cls   = CLS_MOVW;
        dec.undef = 1'b0;
        dec.rd    = rd;
        dec.imm   = {{(DATA_W-HALF_W){1'b0}}, wide_imm};
      end
      OPC_MOVT: begin
        dec.cls   = CLS_MOVT;
        dec.undef = 1'b0;
        dec.rd    = rd;
        dec.imm   = {wide_imm, {(DATA_W-HALF_W){1'b0}}};
      end
      OPC_HINTPSR: begin
        if (rn != '0) begin
          dec.cls   = CLS_PSR_CUR;
          dec.undef = 1'b0;
          dec.imm   = rot_imm;
          dec.mask  = rn;
        end else if (hint_ok) begin
          dec.cls   = CLS_HINT;
          dec.undef = 1'b0;
          dec.hint  = HINT_W'(imm8);
        end
      end
      OPC_PSRSAV: begin
        dec.cls   = CLS_PSR_SAV;
        dec.undef = 1'b0;
        dec.imm   = rot_imm;
        dec.mask  = rn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/misc_imm_outstage.sv
module misc_imm_outstage
  import misc_imm_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  dec_t d,
  output logic out_valid,
  output dec_t q
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          q         <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) q <= d;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign q         = d;
    end
  endgenerate
endmodule

// File: rtl/misc_imm_decoder.sv
module misc_imm_decoder
  import misc_imm_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  output logic              out_valid,
  output logic [2:0]        out_class,
  output logic              out_undef,
  output logic [REG_W-1:0]  out_rd,
  output logic [DATA_W-1:0] out_imm,
  output logic [MASK_W-1:0] out_mask,
  output logic [HINT_W-1:0] out_hint
);
  logic [OPC_W-1:0]  f_opc;
  logic [REG_W-1:0]  f_rn;
  logic [REG_W-1:0]  f_rd;
  logic [ROT_W-1:0]  f_rot;
  logic [IMM8_W-1:0] f_imm8;
  logic [DATA_W-1:0] rot_imm;
  logic [HALF_W-1:0] wide_imm;
  dec_t              dec_d;
  dec_t              dec_q;

  assign f_opc  = in_insn[OPC_LSB +: OPC_W];
  assign f_rn   = in_insn[RN_LSB  +: REG_W];
  assign f_rd   = in_insn[RD_LSB  +: REG_W];
  assign f_rot  = in_insn[ROT_LSB +: ROT_W];
  assign f_imm8 = in_insn[0 +: IMM8_W];

  misc_imm_fields u_fields (
    .rot_amt  (f_rot),
    .imm8     (f_imm8),
    .hi4      (f_rn),
    .lo12     (in_insn[0 +: LO12_W]),
    .rot_imm  (rot_imm),
    .wide_imm (wide_imm)
  );

  misc_imm_classify u_classify (
    .opc      (f_opc),
    .rn       (f_rn),
    .rd       (f_rd),
    .imm8     (f_imm8),
    .rot_imm  (rot_imm),
    .wide_imm (wide_imm),
    .dec      (dec_d)
  );

  misc_imm_outstage #(.REGISTERED(REGISTERED)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .d         (dec_d),
    .out_valid (out_valid),
    .q         (dec_q)
  );

  assign out_class = dec_q.cls;
  assign out_undef = dec_q.undef;
  assign out_rd    = dec_q.rd;
  assign out_imm   = dec_q.imm;
  assign out_mask  = dec_q.mask;
  assign out_hint  = dec_q.hint;
endmodule

// File: rtl/misc_imm_decoder_chk.sv
module misc_imm_decoder_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_insn,
  input logic        out_valid,
  input logic [2:0]  out_class,
  input logic        out_undef,
  input logic [3:0]  out_rd,
  input logic [31:0] out_imm,
  input logic [3:0]  out_mask,
  input logic [2:0]  out_hint
);
  // R11: undefined flag tracks the undefined class code
  assert_undef_flag_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_undef == (out_class == 3'd7)));

  // R5: a hint never carries an immediate, mask or out-of-range kind
  assert_hint_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 3'd2) |-> (out_imm == 32'd0 && out_mask == 4'd0 && out_hint <= 3'd4));

  // R10: undefined results carry no operands
  assert_undef_clean_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_rd == 4'd0 && out_imm == 32'd0 && out_mask == 4'd0 && out_hint == 3'd0));

  generate
    if (REGISTERED) begin : g_seq
      // R1: strobe follows input by one clock
      assert_valid_delay_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      assert_valid_drop_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      // R1: outputs hold across idle cycles
      assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_imm) && $stable(out_class) && $stable(out_rd)));
      // R8: saved-status mask comes from insn[19:16]
      assert_sav_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[24:21] == 4'hB) |=> (out_class == 3'd4 && out_mask == $past(in_insn[19:16])));
      // R3: wide move immediate assembly
      assert_movw_imm_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[24:21] == 4'h8) |=>
          (out_imm == {16'd0, $past(in_insn[19:16]), $past(in_insn[11:0])}));
      // R10: opcodes outside the group are undefined
      assert_out_of_group_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_insn[24:21] < 4'h8 || in_insn[24:21] > 4'hB)) |=> out_undef);
    end
  endgenerate
endmodule

bind misc_imm_decoder misc_imm_decoder_chk #(.REGISTERED(REGISTERED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_insn   (in_insn),
  .out_valid (out_valid),
  .out_class (out_class),
  .out_undef (out_undef),
  .out_rd    (out_rd),
  .out_imm   (out_imm),
  .out_mask  (out_mask),
  .out_hint  (out_hint)
);

// File: tb/misc_imm_decoder_tb_top.sv
`timescale 1ns/1ps
module misc_imm_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = 32'd0;
  logic        out_valid;
  logic [2:0]  out_class;
  logic        out_undef;
  logic [3:0]  out_rd;
  logic [31:0] out_imm;
  logic [3:0]  out_mask;
  logic [2:0]  out_hint;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  misc_imm_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .out_class(out_class), .out_undef(out_undef),
    .out_rd(out_rd), .out_imm(out_imm), .out_mask(out_mask), .out_hint(out_hint)
  );

  typedef struct packed {
    logic [2:0]  cls;
    logic        undef;
    logic [3:0]  rd;
    logic [31:0] imm;
    logic [3:0]  mask;
    logic [2:0]  hint;
  } exp_t;

  function automatic logic [31:0] ref_rot(input logic [7:0] b, input logic [3:0] r);
    logic [31:0] v;
    v = {24'd0, b};
    for (int k = 0; k < 2 * r; k++) v = {v[0], v[31:1]};
    return v;
  endfunction

  function automatic exp_t ref_dec(input logic [31:0] w);
    exp_t e;
    logic [3:0] opc, rn;
    opc = w[24:21];
    rn  = w[19:16];
    e = '0;
    e.cls = 3'd7;
    e.undef = 1'b1;
    if (opc == 4'h8) begin
      e.cls = 3'd0; e.undef = 1'b0; e.rd = w[15:12];
      e.imm = {16'd0, w[19:16], w[11:0]};
    end else if (opc == 4'hA) begin
      e.cls = 3'd1; e.undef = 1'b0; e.rd = w[15:12];
      e.imm = {w[19:16], w[11:0], 16'd0};
    end else if (opc == 4'h9 && rn != 4'd0) begin
      e.cls = 3'd3; e.undef = 1'b0; e.imm = ref_rot(w[7:0], w[11:8]); e.mask = rn;
    end else if (opc == 4'h9 && w[7:0] <= 8'd4) begin
      e.cls = 3'd2; e.undef = 1'b0; e.hint = w[2:0];
    end else if (opc == 4'hB) begin
      e.cls = 3'd4; e.undef = 1'b0; e.imm = ref_rot(w[7:0], w[11:8]); e.mask = rn;
    end
    return e;
  endfunction

  function automatic exp_t got();
    exp_t g;
    g.cls = out_class; g.undef = out_undef; g.rd = out_rd;
    g.imm = out_imm; g.mask = out_mask; g.hint = out_hint;
    return g;
  endfunction

  task automatic check(input string tag, input exp_t e, input logic ev);
    n_checks++;
    if (got() !== e || out_valid !== ev) begin
      n_errors++;
      $display("FAIL %s: got valid=%0b cls=%0d undef=%0b rd=%0d imm=%h mask=%h hint=%0d expected valid=%0b cls=%0d undef=%0b rd=%0d imm=%h mask=%h hint=%0d",
        tag, out_valid, out_class, out_undef, out_rd, out_imm, out_mask, out_hint,
        ev, e.cls, e.undef, e.rd, e.imm, e.mask, e.hint);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] opc, input logic [3:0] rn,
                                     input logic [3:0] rd, input logic [3:0] rot,
                                     input logic [7:0] i8);
    return {7'b0000001, opc, 1'b0, rn, rd, rot, i8};
  endfunction

  // drive on falling edge, result registered at next rising edge, sample at next falling edge
  task automatic apply(input string tag, input logic [31:0] w);
    in_valid = 1'b1;
    in_insn  = w;
    @(negedge clk);
    check(tag, ref_dec(w), 1'b1);
  endtask

  task automatic idle_check(input string tag, input exp_t held, input logic [31:0] junk);
    in_valid = 1'b0;
    in_insn  = junk;
    @(negedge clk);
    check(tag, held, 1'b0);
  endtask

  initial begin
    int unsigned seed;
    logic [31:0] w;
    string tg;
    seed = 32'd20240601;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    check("R2 reset", exp_t'('0), 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset idle", exp_t'('0), 1'b0);

    apply("R3 wide move", mk(4'h8, 4'hA, 4'h5, 4'hF, 8'hC3));
    apply("R4 move top", mk(4'hA, 4'h3, 4'hE, 4'h1, 8'h2B));
    for (int h = 0; h <= 4; h++)
      apply("R5 hint kind", mk(4'h9, 4'h0, 4'h7, 4'h6, 8'(h)));
    apply("R6 hint value 5", mk(4'h9, 4'h0, 4'h0, 4'h0, 8'd5));
    apply("R6 hint value 255", mk(4'h9, 4'h0, 4'h0, 4'h0, 8'hFF));
    apply("R7 current write Rn=1 imm8=0", mk(4'h9, 4'h1, 4'h0, 4'h0, 8'h00));
    apply("R7 current write", mk(4'h9, 4'hF, 4'h2, 4'h4, 8'hA5));
    apply("R8 saved write Rn=0", mk(4'hB, 4'h0, 4'h0, 4'h2, 8'h81));
    apply("R9 rotate zero", mk(4'hB, 4'h9, 4'h0, 4'h0, 8'hFE));
    apply("R9 rotate one", mk(4'h9, 4'h6, 4'h0, 4'h1, 8'h03));
    apply("R9 rotate fifteen", mk(4'hB, 4'hC, 4'h0, 4'hF, 8'h81));
    apply("R10 opcode 7", mk(4'h7, 4'h5, 4'h5, 4'h5, 8'h55));
    apply("R10 opcode C", mk(4'hC, 4'h5, 4'h5, 4'h5, 8'h55));
    apply("R11 opcode 0", mk(4'h0, 4'h0, 4'h0, 4'h0, 8'h00));

    apply("R3 before idle", mk(4'h8, 4'h1, 4'h2, 4'h3, 8'h44));
    idle_check("R1 hold idle 1", ref_dec(mk(4'h8, 4'h1, 4'h2, 4'h3, 8'h44)), mk(4'hB, 4'h1, 4'h0, 4'h1, 8'h77));
    idle_check("R1 hold idle 2", ref_dec(mk(4'h8, 4'h1, 4'h2, 4'h3, 8'h44)), 32'hFFFF_FFFF);

    for (int n = 0; n < 400; n++) begin
      w = $urandom;
      if (n % 2 == 0) w[24:23] = 2'b10;
      if (n % 5 == 0) w[19:16] = 4'd0;
      if (n % 7 == 0) w[7:3] = 5'd0;
      case (ref_dec(w).cls)
        3'd0: tg = "R3 random";
        3'd1: tg = "R4 random";
        3'd2: tg = "R5 random";
        3'd3: tg = "R7 random R9";
        3'd4: tg = "R8 random R9";
        default: tg = "R10 random R6 R11";
      endcase
      apply(tg, w);
      if (n % 13 == 0) idle_check("R1 random idle", ref_dec(w), $urandom);
    end

    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R2 reset mid-stream", exp_t'('0), 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule